// File: doc/BRIEF.md
# Always-On Seconds Counter with Alarm Compare

This block is the timekeeping core of an always-on domain. A slow oscillator pulse, taken from either an internal 32 kHz source or a crystal source, is divided by a prescaler of `DIV_BITS` bits (32768 to one by default) into a once-per-second tick. The tick advances a 32-bit seconds counter. A 32-bit alarm register is compared with the counter on each tick, and a sticky alarm flag is raised on a match. A second sticky flag marks every tick. Each flag drives its own interrupt line through its own enable bit.

Software reaches the core only through command-addressed byte transactions. With chip select high, the first byte carries a direction bit and a register code. A write is followed by its data bytes, most significant first. A read returns one byte on `byte_out` for each further strobe. A read takes a snapshot of the addressed register when the command byte arrives, so the four bytes of a 32-bit value always belong together. A sticky power-on flag lets firmware tell a cold start from a warm one.

The byte slave is a four-state machine. IDLE waits for a command byte. On a command byte it goes to WRITE when bit 7 is 1 and to READ when bit 7 is 0. WRITE goes to DONE when the last data byte arrives. READ stays in READ. DONE ignores further bytes. Any state returns to IDLE when chip select is low.

Top module: `rtc_core`

## Requirements
- R1: After reset the counter and the alarm are 0, the control-0 byte reads 0x05, the control-2 byte reads 0x00, and both interrupt outputs are low.
- R2: Command byte: bit 7 is 1 for a write and 0 for a read, and bits 6:0 are the code. Code 0x00 is the counter, 0x01 the alarm, 0x02 control-0 and 0x04 control-2. 32-bit registers take or return four bytes, most significant first. Control registers take or return one byte. A write takes effect on the second clock after its last byte. Each read strobe places the next byte on `byte_out` after that clock edge.
- R3: The counter increases by one, wrapping from 0xFFFFFFFF to 0, after every 2^DIV_BITS accepted oscillator pulses.
- R4: Writing the counter restarts the prescaler. The first increment after the load comes after a full 2^DIV_BITS accepted pulses.
- R5: A read returns the register value as it stood at the clock edge of the command byte, even if the counter advances during the transaction.
- R6: Control-0 bit 5 is the alarm flag. It is set when a tick makes the counter equal to the alarm, stays set, and is cleared by writing 1 to bit 5. `irq_alarm` equals the flag AND control-0 bit 3.
- R7: Control-0 bit 6 is the tick flag. It is set on every tick and is cleared by writing 1 to bit 6. `irq_sec` equals the flag AND control-0 bit 4. If a set and a clear fall on the same cycle, the set wins for both flags.
- R8: Control-0 bit 0 is the power-on flag. It is 1 after reset, writing 0 clears it, and writing 1 never sets it again.
- R9: Control-2 bit 0 selects the source: 0 for internal pulses gated by control-0 bit 2, 1 for crystal pulses gated by control-0 bit 1. Pulses from an unselected or disabled source do not advance the prescaler.
- R10: Unknown codes read as 0 and writes to them change nothing. Bytes beyond a write's length are ignored. Dropping chip select before the last data byte cancels the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| int_osc_pulse | input | 1 | One-cycle pulse per internal 32 kHz period |
| xtal_osc_pulse | input | 1 | One-cycle pulse per crystal 32 kHz period |
| cs | input | 1 | Transaction select; low ends and resets a transaction |
| byte_valid | input | 1 | Byte strobe, one cycle per byte |
| byte_in | input | 8 | Command or write data byte |
| byte_out | output | 8 | Read data byte |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_sec | output | 1 | Once-per-second interrupt |

## Verification
A prescaler that does not restart on a load moves the first increment by a fraction of a second. This shows up as a counter value off by one in a read taken just before or just after the expected tick. A wrong alarm compare or a flag that is not sticky shows on `irq_alarm` in the very cycle after the faulty tick or clear, because the reference model compares both interrupt lines on every clock. Snapshot or byte-order faults show on `byte_out` within one transaction. Slow reads spread across ticks make a stale or torn capture visible.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 7;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int IDX_W = $clog2(WORD_BYTES);

    localparam logic [CODE_W-1:0] CODE_CNT  = 7'h00;
    localparam logic [CODE_W-1:0] CODE_ALM  = 7'h01;
    localparam logic [CODE_W-1:0] CODE_CTL0 = 7'h02;
    localparam logic [CODE_W-1:0] CODE_CTL2 = 7'h04;

    // control-0 bit positions
    localparam int C0_FIRST = 0;
    localparam int C0_XEN   = 1;
    localparam int C0_IEN   = 2;
    localparam int C0_AIE   = 3;
    localparam int C0_SIE   = 4;
    localparam int C0_AFLG  = 5;
    localparam int C0_SFLG  = 6;
    // control-2 bit positions
    localparam int C2_SRC   = 0;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WR   = 2'd1,
        S_RD   = 2'd2,
        S_DONE = 2'd3
    } slv_state_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic restart,
    output logic sec_tick
);
    localparam logic [DIV_BITS-1:0] TOP = {DIV_BITS{1'b1}};

    logic [DIV_BITS-1:0] div_q;

    assign sec_tick = pulse_in && !restart && (div_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (pulse_in) begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q == '0)); // R4
    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (div_q == '0)); // R3
    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_in && !restart) |=> $stable(div_q)); // R9
endmodule

// File: rtl/rtc_byte_slave.sv
module rtc_byte_slave
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 byte_valid,
    input  logic [BYTE_W-1:0]    byte_in,
    output logic [BYTE_W-1:0]    byte_out,
    output logic [CODE_W-1:0]    rd_code,
    input  logic [WORD_W-1:0]    snap_word,
    output logic                 wr_en,
    output logic [CODE_W-1:0]    wr_code,
    output logic [WORD_W-1:0]    wr_data
);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORD_BYTES - 1);

    slv_state_t          state_q, state_d;
    logic [CODE_W-1:0]   code_q;
    logic [IDX_W-1:0]    idx_q;
    logic [WORD_W-1:0]   sh_q;
    logic [WORD_W-1:0]   sh_in;
    logic [IDX_W-1:0]    last_idx;
    logic [BYTE_W-1:0]   out_q;
    logic                wr_en_q;
    logic [CODE_W-1:0]   wr_code_q;
    logic [WORD_W-1:0]   wr_data_q;

    assign rd_code  = byte_in[CODE_W-1:0];
    assign last_idx = ((code_q == CODE_CNT) || (code_q == CODE_ALM)) ? LAST_WORD : '0;
    assign sh_in    = {sh_q[WORD_W-BYTE_W-1:0], byte_in};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: if (byte_valid) state_d = byte_in[BYTE_W-1] ? S_WR : S_RD;
                S_WR:   if (byte_valid && (idx_q == last_idx)) state_d = S_DONE;
                S_RD:   state_d = S_RD;
                S_DONE: state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // outputs and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= '0;
            idx_q     <= '0;
            sh_q      <= '0;
            out_q     <= '0;
            wr_en_q   <= 1'b0;
            wr_code_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (!cs) begin
                idx_q <= '0;
            end else begin
                unique case (state_q)
                    S_IDLE: begin
                        if (byte_valid) begin
                            code_q <= byte_in[CODE_W-1:0];
                            idx_q  <= '0;
                            sh_q   <= byte_in[BYTE_W-1] ? '0 : snap_word;
                            out_q  <= '0;
                        end
                    end
                    S_WR: begin
                        if (byte_valid) begin
                            sh_q  <= sh_in;
                            idx_q <= idx_q + 1'b1;
                            if (idx_q == last_idx) begin
                                wr_en_q   <= 1'b1;
                                wr_code_q <= code_q;
                                wr_data_q <= sh_in;
                            end
                        end
                    end
                    S_RD: begin
                        if (byte_valid) begin
                            out_q <= sh_q[WORD_W-1 -: BYTE_W];
                            sh_q  <= {sh_q[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                        end
                    end
                    S_DONE: begin
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign byte_out = out_q;
    assign wr_en    = wr_en_q;
    assign wr_code  = wr_code_q;
    assign wr_data  = wr_data_q;

    AST_WR_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> $past(byte_valid && cs)); // R2
    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state_q == S_IDLE)); // R10
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> !wr_en_q); // R10
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_tick,
    input  logic                 wr_en,
    input  logic [CODE_W-1:0]    wr_code,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [CODE_W-1:0]    rd_code,
    output logic [WORD_W-1:0]    rd_word,
    output logic                 load_cnt,
    output logic                 src_xtal,
    output logic                 xtal_en,
    output logic                 int_en,
    output logic                 irq_alarm,
    output logic                 irq_sec
);
    localparam int PAD_W = WORD_W - BYTE_W;

    logic [WORD_W-1:0] cnt_q, alm_q;
    logic [WORD_W-1:0] cnt_inc;
    logic first_q, xen_q, ien_q, aie_q, sie_q, aflg_q, sflg_q, src_q;
    logic wr_alm, wr_c0, wr_c2;
    logic set_a, set_s;
    logic [BYTE_W-1:0] c0_byte, c2_byte;

    assign load_cnt = wr_en && (wr_code == CODE_CNT);
    assign wr_alm   = wr_en && (wr_code == CODE_ALM);
    assign wr_c0    = wr_en && (wr_code == CODE_CTL0);
    assign wr_c2    = wr_en && (wr_code == CODE_CTL2);
    assign cnt_inc  = cnt_q + 1'b1;
    assign set_s    = sec_tick && !load_cnt;
    assign set_a    = set_s && (cnt_inc == alm_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_cnt) begin
            cnt_q <= wr_data;
        end else if (sec_tick) begin
            cnt_q <= cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_q   <= '0;
            first_q <= 1'b1;
            xen_q   <= 1'b0;
            ien_q   <= 1'b1;
            aie_q   <= 1'b0;
            sie_q   <= 1'b0;
            aflg_q  <= 1'b0;
            sflg_q  <= 1'b0;
            src_q   <= 1'b0;
        end else begin
            if (wr_alm) alm_q <= wr_data;
            if (wr_c0) begin
                first_q <= first_q & wr_data[C0_FIRST];
                xen_q   <= wr_data[C0_XEN];
                ien_q   <= wr_data[C0_IEN];
                aie_q   <= wr_data[C0_AIE];
                sie_q   <= wr_data[C0_SIE];
                aflg_q  <= (aflg_q & ~wr_data[C0_AFLG]) | set_a;
                sflg_q  <= (sflg_q & ~wr_data[C0_SFLG]) | set_s;
            end else begin
                aflg_q  <= aflg_q | set_a;
                sflg_q  <= sflg_q | set_s;
            end
            if (wr_c2) src_q <= wr_data[C2_SRC];
        end
    end

    always_comb begin
        c0_byte = '0;
        c0_byte[C0_FIRST] = first_q;
        c0_byte[C0_XEN]   = xen_q;
        c0_byte[C0_IEN]   = ien_q;
        c0_byte[C0_AIE]   = aie_q;
        c0_byte[C0_SIE]   = sie_q;
        c0_byte[C0_AFLG]  = aflg_q;
        c0_byte[C0_SFLG]  = sflg_q;
        c2_byte = '0;
        c2_byte[C2_SRC]   = src_q;
    end

    always_comb begin
        unique case (rd_code)
            CODE_CNT:  rd_word = cnt_q;
            CODE_ALM:  rd_word = alm_q;
            CODE_CTL0: rd_word = {c0_byte, {PAD_W{1'b0}}};
            CODE_CTL2: rd_word = {c2_byte, {PAD_W{1'b0}}};
            default:   rd_word = '0;
        endcase
    end

    assign src_xtal  = src_q;
    assign xtal_en   = xen_q;
    assign int_en    = ien_q;
    assign irq_alarm = aflg_q & aie_q;
    assign irq_sec   = sflg_q & sie_q;

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (cnt_q == $past(wr_data))); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_cnt && !sec_tick) |=> $stable(cnt_q)); // R3
    AST_FIRST_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !first_q |=> !first_q); // R8
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (aflg_q && !(wr_c0 && wr_data[C0_AFLG])) |=> aflg_q); // R6
    AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sflg_q && !(wr_c0 && wr_data[C0_SFLG])) |=> sflg_q); // R7
    AST_ALARM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_cnt && (cnt_q + 32'd1 == alm_q)) |=> aflg_q); // R6
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        int_osc_pulse,
    input  logic        xtal_osc_pulse,
    input  logic        cs,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    output logic [7:0]  byte_out,
    output logic        irq_alarm,
    output logic        irq_sec
);
    logic              sec_tick, load_cnt;
    logic              src_xtal, xtal_en, int_en;
    logic              src_pulse;
    logic [CODE_W-1:0] rd_code, wr_code;
    logic [WORD_W-1:0] snap_word, wr_data;
    logic              wr_en;

    assign src_pulse = src_xtal ? (xtal_osc_pulse && xtal_en)
                                : (int_osc_pulse && int_en);

    rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (src_pulse),
        .restart  (load_cnt),
        .sec_tick (sec_tick)
    );

    rtc_byte_slave u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .byte_out   (byte_out),
        .rd_code    (rd_code),
        .snap_word  (snap_word),
        .wr_en      (wr_en),
        .wr_code    (wr_code),
        .wr_data    (wr_data)
    );

    rtc_timekeep u_keep (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .wr_data   (wr_data),
        .rd_code   (rd_code),
        .rd_word   (snap_word),
        .load_cnt  (load_cnt),
        .src_xtal  (src_xtal),
        .xtal_en   (xtal_en),
        .int_en    (int_en),
        .irq_alarm (irq_alarm),
        .irq_sec   (irq_sec)
    );

    AST_TICK_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> src_pulse); // R9
endmodule

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;
    localparam int DIVB = 3;
    localparam int DIVN = 1 << DIVB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_p = 1'b0, xtal_p = 1'b0;
    logic cs = 1'b0, bv = 1'b0;
    logic [7:0] bi = 8'h00;
    logic [7:0] byte_out;
    logic irq_alarm, irq_sec;

    always #4 clk = ~clk;

    rtc_core #(.DIV_BITS(DIVB)) u0 (
        .clk(clk), .rst_n(rst_n), .int_osc_pulse(int_p), .xtal_osc_pulse(xtal_p),
        .cs(cs), .byte_valid(bv), .byte_in(bi), .byte_out(byte_out),
        .irq_alarm(irq_alarm), .irq_sec(irq_sec)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_cnt = 0, m_alm = 0;
    int m_pre = 0;
    logic m_first = 1, m_xen = 0, m_ien = 1, m_aie = 0, m_sie = 0;
    logic m_af = 0, m_sf = 0, m_src = 0;
    logic pend = 0;
    logic [6:0] pcode = 0;
    logic [31:0] pdata = 0;

    // oscillator pulse generators
    bit gen_int = 0, gen_xtal = 0;
    int ph = 0;
    always @(negedge clk) begin
        ph = ph + 1;
        if (gen_int) int_p = (ph % 3 == 0);
        if (gen_xtal) xtal_p = (ph % 5 == 0);
    end

    function automatic logic [7:0] m_c0();
        return {1'b0, m_sf, m_af, m_sie, m_aie, m_ien, m_xen, m_first};
    endfunction

    function automatic logic [31:0] m_read(input logic [6:0] code);
        case (code)
            7'h00: return m_cnt;
            7'h01: return m_alm;
            7'h02: return {24'h0, m_c0()};
            7'h04: return {31'h0, m_src};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            logic sel, set_a, set_s;
            sel = m_src ? (xtal_p && m_xen) : (int_p && m_ien);
            set_a = 0; set_s = 0;
            if (pend && pcode == 7'h00) begin
                m_cnt = pdata; m_pre = 0;
            end else if (sel) begin
                m_pre = m_pre + 1;
                if (m_pre == DIVN) begin
                    m_pre = 0;
                    m_cnt = m_cnt + 1;
                    set_s = 1;
                    if (m_cnt == m_alm) set_a = 1;
                end
            end
            if (pend) begin
                case (pcode)
                    7'h01: m_alm = pdata;
                    7'h02: begin
                        m_first = m_first & pdata[0];
                        m_xen = pdata[1]; m_ien = pdata[2];
                        m_aie = pdata[3]; m_sie = pdata[4];
                        if (pdata[5]) m_af = 0;
                        if (pdata[6]) m_sf = 0;
                    end
                    7'h04: m_src = pdata[0];
                    default: ;
                endcase
            end
            m_af = m_af | set_a;
            m_sf = m_sf | set_s;
            pend = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // interrupt lines against model every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(irq_alarm == (m_af & m_aie), "R6 irq_alarm", {31'h0, irq_alarm}, {31'h0, m_af & m_aie});
            check(irq_sec == (m_sf & m_sie), "R7 irq_sec", {31'h0, irq_sec}, {31'h0, m_sf & m_sie});
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); bv = 1; bi = b;
        @(negedge clk); bv = 0;
    endtask

    task automatic wr_reg(input logic [6:0] code, input logic [31:0] data, input int extra);
        int n;
        n = (code == 7'h00 || code == 7'h01) ? 4 : 1;
        @(negedge clk); cs = 1;
        send_byte({1'b1, code});
        for (int i = n - 1; i >= 0; i--) send_byte(data[i*8 +: 8]);
        pend = 1; pcode = code; pdata = (n == 4) ? data : {24'h0, data[7:0]};
        for (int i = 0; i < extra; i++) send_byte(8'hFF);
        @(negedge clk); cs = 0;
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [6:0] code, input int gap, input string tag, output logic [31:0] got);
        int n;
        logic [31:0] exp;
        n = (code == 7'h00 || code == 7'h01) ? 4 : 1;
        got = 0;
        @(negedge clk); cs = 1;
        @(negedge clk); exp = m_read(code); bv = 1; bi = {1'b0, code};
        @(negedge clk); bv = 0;
        for (int i = 0; i < n; i++) begin
            repeat (gap) @(negedge clk);
            send_byte(8'h00);
            got = (n == 4) ? {got[23:0], byte_out} : {24'h0, byte_out};
        end
        @(negedge clk); cs = 0;
        @(negedge clk);
        check(got == exp, tag, got, exp);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); int_p = 1;
            @(negedge clk); int_p = 0;
        end
    endtask

    initial begin
        logic [31:0] v, v2;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(irq_alarm == 0 && irq_sec == 0, "R1 irq reset", {30'h0, irq_alarm, irq_sec}, 0);
        rd_reg(7'h02, 0, "R1 R8 ctrl0 reset", v);
        check(v == 32'h05, "R1 ctrl0 literal", v, 32'h05);
        rd_reg(7'h04, 0, "R1 ctrl2 reset", v);
        rd_reg(7'h00, 0, "R1 counter reset", v);
        rd_reg(7'h01, 0, "R1 alarm reset", v);

        // R2 R8: alarm round trip, clear power-on flag, enable interrupts
        wr_reg(7'h01, 32'hA1B2C3D4, 0);
        rd_reg(7'h01, 0, "R2 alarm byte order", v);
        check(v == 32'hA1B2C3D4, "R2 alarm literal", v, 32'hA1B2C3D4);
        wr_reg(7'h02, 32'h1C, 0);
        rd_reg(7'h02, 0, "R8 first flag cleared", v);
        check(v[0] == 0, "R8 bit0 zero", v, 0);
        wr_reg(7'h02, 32'h1D, 0);
        rd_reg(7'h02, 0, "R8 first flag not set by 1", v);
        check(v[0] == 0, "R8 bit0 stays zero", v, 0);

        // R3 R9: internal source counting
        gen_int = 1;
        repeat (200) @(negedge clk);
        rd_reg(7'h00, 0, "R3 counter after run", v);
        check(v > 0, "R3 counter advanced", v, 1);

        // R4: exact restart after load
        gen_int = 0; int_p = 0;
        repeat (3) @(negedge clk);
        pulses(3);
        wr_reg(7'h00, 32'h00000500, 0);
        pulses(DIVN - 1);
        rd_reg(7'h00, 0, "R4 no tick before full period", v);
        check(v == 32'h500, "R4 literal hold", v, 32'h500);
        pulses(1);
        rd_reg(7'h00, 0, "R4 tick after full period", v);
        check(v == 32'h501, "R4 literal step", v, 32'h501);

        // R3 wrap
        wr_reg(7'h00, 32'hFFFFFFFF, 0);
        pulses(DIVN);
        rd_reg(7'h00, 0, "R3 wrap to zero", v);
        check(v == 0, "R3 wrap literal", v, 0);

        // R6 R7: alarm and tick flags
        wr_reg(7'h00, 32'd100, 0);
        wr_reg(7'h01, 32'd103, 0);
        gen_int = 1;
        repeat (120) @(negedge clk);
        check(irq_alarm == 1, "R6 alarm raised", {31'h0, irq_alarm}, 1);
        rd_reg(7'h02, 0, "R6 ctrl0 flags", v);
        wr_reg(7'h02, 32'h3C, 0);
        rd_reg(7'h02, 0, "R6 alarm flag cleared", v);
        check(v[5] == 0, "R6 W1C literal", v, 0);
        wr_reg(7'h02, 32'h5C, 0);
        repeat (40) @(negedge clk);
        rd_reg(7'h02, 0, "R7 tick flag after clear and rerun", v);

        // R5: slow read spanning ticks
        rd_reg(7'h00, 30, "R5 snapshot coherent", v);

        // R9: crystal selected but disabled
        gen_xtal = 1;
        wr_reg(7'h04, 32'h01, 0);
        rd_reg(7'h00, 0, "R9 counter while disabled", v);
        repeat (100) @(negedge clk);
        rd_reg(7'h00, 0, "R9 disabled source ignored", v2);
        check(v2 == v, "R9 held literal", v2, v);
        wr_reg(7'h02, 32'h1A, 0);
        repeat (200) @(negedge clk);
        rd_reg(7'h00, 0, "R9 crystal counts", v2);
        check(v2 != v, "R9 crystal advanced", v2, v);

        // R10: unknown code, extra bytes, abort
        wr_reg(7'h03, 32'h77, 0);
        rd_reg(7'h03, 0, "R10 unknown reads zero", v);
        wr_reg(7'h04, 32'h00, 2);
        rd_reg(7'h04, 0, "R10 extra bytes ignored", v);
        gen_int = 0; gen_xtal = 0; int_p = 0; xtal_p = 0;
        repeat (4) @(negedge clk);
        rd_reg(7'h00, 0, "R10 counter before abort", v);
        @(negedge clk); cs = 1;
        send_byte(8'h80); send_byte(8'h12); send_byte(8'h34);
        @(negedge clk); cs = 0;
        repeat (3) @(negedge clk);
        rd_reg(7'h00, 0, "R10 aborted write", v2);
        check(v2 == v, "R10 abort literal", v2, v);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=0x00000000 expected=0x00000001");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule